// File: doc/BRIEF.md
# Serial Adapter Host Register Port with Interrupts

This block is the processor-facing register front end of a byte-wide asynchronous serial adapter. A host reaches it through a 2-bit offset, separate read and write strobes and 8-bit data. Behind those four offsets sit a one-byte receive holder, a one-byte transmit holder, a read-only status view, a command register and a control register. Bit timing and baud generation live elsewhere. On the line side the block sees a byte arrive as a single-cycle strobe with its data. It offers the pending transmit byte with a valid flag, and the line side takes that byte with a one-cycle accept pulse.

An active-high, level-sensitive interrupt request tells the host that a byte has arrived or that the transmit holder has been emptied by the line side. Each of the two sources has its own enable, decoded from the command register, and the receive enable is active-low. The request stays high until every enabled pending condition has been served. Reading the data offset serves the receive condition. Loading a new transmit byte serves the transmit condition. Any write to the status offset, or a write of zero to the control offset, performs a programmed reset of the adapter state.

Top module: `serial_host_port`

## Requirements
- R1: A host read of offset 0 returns the held receive byte on `bus_rdata` in the cycle after the read strobe; `bus_rdata` holds its value while no read is issued.
- R2: A read of offset 1 returns status: bit 4 = transmit holder empty, bit 3 = receive byte held, all other bits 0. The status cannot be written.
- R3: A line-side receive strobe latches the byte and sets receive-full; a host read of offset 0 clears receive-full.
- R4: A host write to offset 0 loads the transmit byte and raises `line_tx_valid` with that byte on `line_tx_byte`; a `line_tx_accept` pulse while valid empties the holder again.
- R5: The receive interrupt is enabled when command bit 1 is 0, and is then requested while a receive byte is held.
- R6: The transmit interrupt is enabled only when command bit 3 is 0 and command bit 2 is 1. It is requested once the line side has taken a byte and is withdrawn by the next data write; loading the data register by itself never raises `irq`.
- R7: Any write to offset 1 resets the adapter: transmit holder empty, receive-full clear, receive byte 0, command and control 0, both interrupt enables off, `irq` low.
- R8: A write of 0 to offset 3 performs the same reset as R7; a nonzero write is stored and reads back at offset 3.
- R9: The command register reads back at offset 2 the last value written.
- R10: After the synchronous reset input, status reads 0x10, `irq` and `line_tx_valid` are low and `bus_rdata` is 0.
- R11: `irq` is the OR of both enabled pending sources, updated one cycle after the state that causes it, and stays high until every enabled pending source is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request, active high |
| line_rx_stb | input | 1 | Received byte strobe |
| line_rx_byte | input | 8 | Received byte |
| line_tx_valid | output | 1 | Transmit byte pending |
| line_tx_byte | output | 8 | Pending transmit byte |
| line_tx_accept | input | 1 | Line side takes the pending byte |

## Verification
Holder and register state changes on the clock edge that samples a strobe. A read result appears on `bus_rdata` after the edge that samples the read. `irq` follows one edge later than the state that drives it, because it is a registered output. The bench drives each strobe for a single cycle between falling edges. It samples read data at the falling edge after the sampling edge, and samples `irq` one full cycle later than the state change. The sweep covers all 256 command values, checking each receive and transmit enable decode along that timing. Directed cases cover both-source overlap and the two forms of programmed reset.

// File: rtl/shp_pkg.sv
package shp_pkg;
  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_STAT = 2'd1,
    OFS_CMD  = 2'd2,
    OFS_CTRL = 2'd3
  } ofs_e;

  localparam int ST_TXE_BIT    = 4;
  localparam int ST_RXF_BIT    = 3;
  localparam int CMD_RXOFF_BIT = 1;
  localparam int CMD_TXON_BIT  = 2;
  localparam int CMD_TXBLK_BIT = 3;
endpackage

// File: rtl/shp_rx_hold.sv
module shp_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              arr_stb,
  input  logic [DATA_W-1:0] arr_byte,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full <= 1'b0;
      data <= '0;
    end else if (arr_stb) begin
      full <= 1'b1;
      data <= arr_byte;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  AST_RX_LATCH: assert property (@(posedge clk) disable iff (rst)
    (arr_stb && !clr) |=> (full && data == $past(arr_byte))); // R3
  AST_RX_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (take && !arr_stb && !clr) |=> !full); // R3
endmodule

// File: rtl/shp_tx_hold.sv
module shp_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              accept,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full <= 1'b0;
      data <= '0;
      done <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
      data <= load_byte;
      done <= 1'b0;
    end else if (accept && full) begin
      full <= 1'b0;
      done <= 1'b1;
    end
  end

  AST_TX_LOAD_VALID: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (full && !done && data == $past(load_byte))); // R4
  AST_TX_ACCEPT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (accept && full && !load && !clr) |=> (!full && done)); // R6
  AST_TX_DONE_ONLY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(accept)); // R6
endmodule

// File: rtl/shp_ctl_regs.sv
module shp_ctl_regs
  import shp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cmd_wr,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              rx_en,
  output logic              tx_en
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cmd_q  <= '0;
      ctrl_q <= '0;
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
    end else if (cmd_wr) begin
      cmd_q <= wdata;
      rx_en <= ~wdata[CMD_RXOFF_BIT];
      tx_en <= wdata[CMD_TXON_BIT] & ~wdata[CMD_TXBLK_BIT];
    end else if (ctrl_wr) begin
      ctrl_q <= wdata;
    end
  end

  AST_CMD_RX_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !clr) |=> (rx_en == !$past(wdata[CMD_RXOFF_BIT]))); // R5
  AST_CLR_DROPS_ENABLES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!rx_en && !tx_en && cmd_q == '0)); // R7
endmodule

// File: rtl/serial_host_port.sv
module serial_host_port
  import shp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              line_rx_stb,
  input  logic [DATA_W-1:0] line_rx_byte,
  output logic              line_tx_valid,
  output logic [DATA_W-1:0] line_tx_byte,
  input  logic              line_tx_accept
);
  logic              soft_clr;
  logic              rx_full, tx_full, tx_done, rx_en, tx_en;
  logic [DATA_W-1:0] rx_data, cmd_q, ctrl_q, status_v, rd_mux;
  logic              wr_data, wr_cmd, wr_ctrl, rd_data;

  assign wr_data  = bus_wr && (bus_addr == OFS_DATA);
  assign wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign rd_data  = bus_rd && (bus_addr == OFS_DATA);
  assign soft_clr = bus_wr && ((bus_addr == OFS_STAT) ||
                               (bus_addr == OFS_CTRL && bus_wdata == '0));

  shp_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .clr(soft_clr),
    .arr_stb(line_rx_stb), .arr_byte(line_rx_byte), .take(rd_data),
    .full(rx_full), .data(rx_data)
  );

  shp_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .clr(soft_clr),
    .load(wr_data), .load_byte(bus_wdata), .accept(line_tx_accept),
    .full(tx_full), .data(line_tx_byte), .done(tx_done)
  );

  shp_ctl_regs #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .clr(soft_clr),
    .cmd_wr(wr_cmd), .ctrl_wr(wr_ctrl), .wdata(bus_wdata),
    .cmd_q(cmd_q), .ctrl_q(ctrl_q), .rx_en(rx_en), .tx_en(tx_en)
  );

  assign line_tx_valid = tx_full;

  always_comb begin
    status_v             = '0;
    status_v[ST_TXE_BIT] = ~tx_full;
    status_v[ST_RXF_BIT] = rx_full;
  end

  always_comb begin
    case (ofs_e'(bus_addr))
      OFS_DATA: rd_mux = rx_data;
      OFS_STAT: rd_mux = status_v;
      OFS_CMD:  rd_mux = cmd_q;
      default:  rd_mux = ctrl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= !soft_clr && ((rx_full && rx_en) || (tx_done && tx_en));
    end
  end

  AST_SOFT_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_STAT) |=> (!line_tx_valid && !rx_full)); // R7
  AST_SOFT_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_STAT) |=> !irq); // R7
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(rx_en) || $past(tx_en))); // R11
endmodule

// File: tb/test_serial_host_port.sv
module test_serial_host_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       line_rx_stb = 1'b0;
  logic [7:0] line_rx_byte = 8'h00;
  logic       line_tx_valid;
  logic [7:0] line_tx_byte;
  logic       line_tx_accept = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_host_port i_serial_host_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .line_rx_stb(line_rx_stb), .line_rx_byte(line_rx_byte),
    .line_tx_valid(line_tx_valid), .line_tx_byte(line_tx_byte),
    .line_tx_accept(line_tx_accept)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    line_rx_stb = 1'b1; line_rx_byte = b;
    @(negedge clk);
    line_rx_stb = 1'b0;
  endtask

  task automatic tx_take();
    @(negedge clk);
    line_tx_accept = 1'b1;
    @(negedge clk);
    line_tx_accept = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    // R10: reset state
    check("R10 rdata", bus_rdata, 8'h00);
    check("R10 irq", {7'd0, irq}, 8'h00);
    check("R10 txvalid", {7'd0, line_tx_valid}, 8'h00);
    bus_read(2'd1, rd);
    check("R10 status", rd, 8'h10);
    bus_read(2'd0, rd);
    check("R1 rdata hold", bus_rdata, rd);

    // Sweep every command value
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cv, rb, tb;
      logic rx_on, tx_on;
      cv = 8'(c);
      rb = cv ^ 8'h5A;
      tb = ~cv;
      rx_on = ~cv[1];
      tx_on = cv[2] & ~cv[3];
      bus_write(2'd1, 8'hFF);
      bus_write(2'd2, cv);
      bus_read(2'd2, rd);
      check("R9 cmd readback", rd, cv);
      rx_push(rb);
      tick();
      check("R5 rx irq", {7'd0, irq}, {7'd0, rx_on});
      bus_read(2'd1, rd);
      check("R2 status rx full", rd, 8'h18);
      bus_read(2'd0, rd);
      check("R1 R3 rx byte", rd, rb);
      tick();
      check("R11 irq after rx read", {7'd0, irq}, 8'h00);
      bus_read(2'd1, rd);
      check("R3 status after read", rd, 8'h10);
      bus_write(2'd0, tb);
      check("R4 tx valid", {7'd0, line_tx_valid}, 8'h01);
      check("R4 tx byte", line_tx_byte, tb);
      bus_read(2'd1, rd);
      check("R2 status tx busy", rd, 8'h00);
      check("R6 no irq on load", {7'd0, irq}, 8'h00);
      tx_take();
      check("R4 tx emptied", {7'd0, line_tx_valid}, 8'h00);
      tick();
      check("R6 tx irq", {7'd0, irq}, {7'd0, tx_on});
      bus_write(2'd0, tb ^ 8'hFF);
      tick();
      check("R6 irq withdrawn by load", {7'd0, irq}, 8'h00);
      tx_take();
    end

    // R11: both sources pending
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'h04);
    bus_write(2'd0, 8'hA5);
    tx_take();
    rx_push(8'h3C);
    tick();
    check("R11 both irq", {7'd0, irq}, 8'h01);
    bus_read(2'd0, rd);
    tick();
    check("R11 irq held by tx", {7'd0, irq}, 8'h01);
    bus_write(2'd0, 8'h11);
    tick();
    check("R11 irq cleared", {7'd0, irq}, 8'h00);

    // R2: status write does not stick (it resets)
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, rd);
    check("R2 status not writable", rd, 8'h10);

    // R7: programmed reset via offset 1
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'h1A);
    rx_push(8'h77);
    bus_write(2'd0, 8'h42);
    bus_write(2'd1, 8'h00);
    check("R7 tx empty", {7'd0, line_tx_valid}, 8'h00);
    tick();
    check("R7 irq low", {7'd0, irq}, 8'h00);
    bus_read(2'd1, rd);
    check("R7 status", rd, 8'h10);
    bus_read(2'd0, rd);
    check("R7 rx byte", rd, 8'h00);
    bus_read(2'd2, rd);
    check("R7 cmd", rd, 8'h00);
    bus_read(2'd3, rd);
    check("R7 ctrl", rd, 8'h00);
    rx_push(8'h99);
    tick();
    check("R7 enables off", {7'd0, irq}, 8'h00);
    bus_read(2'd0, rd);

    // R8: control register store and zero-write reset
    for (int v = 1; v < 256; v += 37) begin
      bus_write(2'd3, 8'(v));
      bus_read(2'd3, rd);
      check("R8 ctrl readback", rd, 8'(v));
    end
    bus_write(2'd2, 8'h00);
    rx_push(8'h5E);
    bus_write(2'd3, 8'h00);
    bus_read(2'd1, rd);
    check("R8 zero ctrl resets", rd, 8'h10);
    bus_read(2'd2, rd);
    check("R8 cmd cleared", rd, 8'h00);
    tick();
    check("R8 irq low", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule